// File: doc/BRIEF.md
# Alternating Two-Pattern Bit Sequencer

The block stores two user bit patterns, A and B, and plays them out one bit per clock in alternation. Pattern A is played for a configured number of complete passes, then pattern B for its own configured number of passes, after which the A/B cycle starts over and repeats without end. Both patterns share a single length, set as a whole number of 128-bit blocks. Pattern memories are loaded through a one-bit write port and are laid out so that a block RAM can be inferred.

Each output bit is accompanied by a status bit telling which pattern it belongs to, and by a one-clock marker on the first bit of every pass. Configuration inputs are captured on reset and again only at the boundary where a full A/B cycle ends, so a change made in the middle of a cycle never produces a truncated or mixed cycle.

Top module: `ab_pattern_sequencer`

## Requirements
- R1: While `rst` is high at a rising edge, the following outputs are `dout`=0, `pat_is_b`=0, `pass_start`=0; on the first edge with `rst` low the outputs present bit 0 of pattern A with `pass_start`=1.
- R2: A rising edge with `wr_en`=1 stores `wr_data` at bit index `wr_addr` of pattern A when `wr_sel`=0 or of pattern B when `wr_sel`=1, whether or not the block is in reset; the other pattern is untouched.
- R3: The pass length is `cfg_blocks`×128 bits, and within a pass the bits appear at successive clocks in index order 0, 1, … length−1.
- R4: A `cfg_blocks` of 0 is taken as 1 block, and a value above MAX_BLOCKS (default 8) is taken as MAX_BLOCKS.
- R5: Pattern A is played for `cfg_loops_a` consecutive passes, then pattern B for `cfg_loops_b` passes, and this cycle repeats.
- R6: A loop count of 0 is treated as 1; counts up to 127 are honoured.
- R7: `pass_start` is 1 exactly on the clock that presents bit 0 of a pass, and 0 otherwise.
- R8: `pat_is_b` is 1 exactly when the bit on `dout` comes from pattern B, and changes only together with `pass_start` (or on leaving reset).
- R9: Changes of `cfg_blocks`, `cfg_loops_a` or `cfg_loops_b` take effect only at the start of the next A/B cycle (after the last bit of the last B pass) or through reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; restarts at A bit 0 and captures configuration |
| wr_en | input | 1 | Pattern memory write strobe |
| wr_sel | input | 1 | Write target: 0 = pattern A, 1 = pattern B |
| wr_addr | input | 10 | Bit index to write (log2 of MAX_BLOCKS×128) |
| wr_data | input | 1 | Bit value to write |
| cfg_blocks | input | 4 | Pass length in 128-bit blocks |
| cfg_loops_a | input | 7 | Consecutive passes of pattern A |
| cfg_loops_b | input | 7 | Consecutive passes of pattern B |
| dout | output | 1 | Serial pattern bit |
| pat_is_b | output | 1 | 1 while the presented bit belongs to pattern B |
| pass_start | output | 1 | 1 on the first bit of every pass |

## Verification
The sequencer is driven with loop-count pairs that are equal, unequal in both directions, zero and at the 127 maximum, and with lengths of one, two, zero (normalised) and an over-range block count; a short symmetric setting separates A/B switching errors from address errors, while the lopsided settings expose off-by-one pass counting on either side. The two pattern contents are different pseudo-random bit sequences, so playing the wrong pattern, the wrong bit index or the wrong block is visible on `dout`. A configuration change in the middle of a cycle, a reset in the middle of a B pass, and a single-bit overwrite of one pattern show that captured settings, restart and write selection behave as stated.

// File: rtl/ab_seq_pkg.sv
package ab_seq_pkg;

  localparam int LOOP_W = 7;

  typedef logic [LOOP_W-1:0] loop_t;

  typedef enum logic {
    PAT_A = 1'b0,
    PAT_B = 1'b1
  } pat_sel_e;

endpackage

// File: rtl/ab_cfg_latch.sv
module ab_cfg_latch
  import ab_seq_pkg::*;
#(
  parameter int MAX_BLOCKS = 8,
  parameter int BLK_W      = $clog2(MAX_BLOCKS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [BLK_W-1:0] cfg_blocks,
  input  loop_t            cfg_loops_a,
  input  loop_t            cfg_loops_b,
  output logic [BLK_W-1:0] blocks_q,
  output loop_t            loops_a_q,
  output loop_t            loops_b_q
);

  localparam int NUM_PAT = 2;

  loop_t            raw_cnt  [NUM_PAT];
  loop_t            norm_cnt [NUM_PAT];
  logic [BLK_W-1:0] blk_norm;

  assign raw_cnt[0] = cfg_loops_a;
  assign raw_cnt[1] = cfg_loops_b;

  // zero repetitions would stall the cycle: promote to one pass
  for (genvar g = 0; g < NUM_PAT; g++) begin : g_norm
    assign norm_cnt[g] = (raw_cnt[g] == '0) ? loop_t'(1) : raw_cnt[g];
  end

  always_comb begin
    if (cfg_blocks == '0)
      blk_norm = BLK_W'(1);
    else if (cfg_blocks > BLK_W'(MAX_BLOCKS))
      blk_norm = BLK_W'(MAX_BLOCKS);
    else
      blk_norm = cfg_blocks;
  end

  always_ff @(posedge clk) begin
    if (rst || load) begin
      blocks_q  <= blk_norm;
      loops_a_q <= norm_cnt[0];
      loops_b_q <= norm_cnt[1];
    end
  end

  a_r6_counts_nonzero: assert property (@(posedge clk) disable iff (rst)
    (loops_a_q != '0) && (loops_b_q != '0));

  a_r4_blocks_in_range: assert property (@(posedge clk) disable iff (rst)
    (blocks_q != '0) && (blocks_q <= BLK_W'(MAX_BLOCKS)));

  a_r9_cfg_held: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable({blocks_q, loops_a_q, loops_b_q}));

endmodule

// File: rtl/ab_addr_gen.sv
module ab_addr_gen #(
  parameter int BLOCK_BITS = 128,
  parameter int MAX_BLOCKS = 8,
  parameter int BLK_W      = $clog2(MAX_BLOCKS + 1),
  parameter int ADDR_W     = $clog2(BLOCK_BITS * MAX_BLOCKS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BLK_W-1:0]  blocks,
  output logic [ADDR_W-1:0] addr,
  output logic              at_last
);

  localparam int LEN_W = ADDR_W + 1;

  logic [LEN_W-1:0] len_bits;
  logic [LEN_W-1:0] last_idx;

  assign len_bits = LEN_W'(blocks) * LEN_W'(BLOCK_BITS);
  assign last_idx = len_bits - LEN_W'(1);
  assign at_last  = ({1'b0, addr} == last_idx);

  always_ff @(posedge clk) begin
    if (rst)
      addr <= '0;
    else if (at_last)
      addr <= '0;
    else
      addr <= addr + ADDR_W'(1);
  end

  a_r3_addr_bound: assert property (@(posedge clk) disable iff (rst)
    {1'b0, addr} < len_bits);

  a_r3_wraps_to_zero: assert property (@(posedge clk) disable iff (rst)
    at_last |=> (addr == '0));

  a_r3_steps_by_one: assert property (@(posedge clk) disable iff (rst)
    !at_last |=> (addr == $past(addr) + ADDR_W'(1)));

endmodule

// File: rtl/ab_loop_ctrl.sv
module ab_loop_ctrl
  import ab_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     at_last,
  input  loop_t    loops_a,
  input  loop_t    loops_b,
  output pat_sel_e cur_sel,
  output logic     cycle_end
);

  loop_t pass_idx;
  loop_t limit;
  logic  pass_last;

  assign limit     = (cur_sel == PAT_B) ? loops_b : loops_a;
  assign pass_last = (pass_idx == limit - loop_t'(1));
  assign cycle_end = at_last && pass_last && (cur_sel == PAT_B);

  always_ff @(posedge clk) begin
    if (rst) begin
      pass_idx <= '0;
      cur_sel  <= PAT_A;
    end else if (at_last) begin
      if (pass_last) begin
        pass_idx <= '0;
        cur_sel  <= (cur_sel == PAT_A) ? PAT_B : PAT_A;
      end else begin
        pass_idx <= pass_idx + loop_t'(1);
      end
    end
  end

  a_r5_pass_bound: assert property (@(posedge clk) disable iff (rst)
    pass_idx < limit);

  a_r5_hold_mid_run: assert property (@(posedge clk) disable iff (rst)
    !(at_last && pass_last) |=> $stable(cur_sel));

  a_r5_swap_after_run: assert property (@(posedge clk) disable iff (rst)
    (at_last && pass_last) |=> (cur_sel != $past(cur_sel)));

endmodule

// File: rtl/ab_pat_mem.sv
module ab_pat_mem #(
  parameter int DEPTH = 2048,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic          wdata,
  input  logic [AW-1:0] raddr,
  output logic          q
);

  logic mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we)
      mem[waddr] <= wdata;
  end

  // registered read port with synchronous output reset
  always_ff @(posedge clk) begin
    if (rst)
      q <= 1'b0;
    else
      q <= mem[raddr];
  end

endmodule

// File: rtl/ab_pattern_sequencer.sv
module ab_pattern_sequencer
  import ab_seq_pkg::*;
#(
  parameter  int BLOCK_BITS = 128,
  parameter  int MAX_BLOCKS = 8,
  localparam int PAT_DEPTH  = BLOCK_BITS * MAX_BLOCKS,
  localparam int ADDR_W     = $clog2(PAT_DEPTH),
  localparam int BLK_W      = $clog2(MAX_BLOCKS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wr_data,
  input  logic [BLK_W-1:0]  cfg_blocks,
  input  logic [LOOP_W-1:0] cfg_loops_a,
  input  logic [LOOP_W-1:0] cfg_loops_b,
  output logic              dout,
  output logic              pat_is_b,
  output logic              pass_start
);

  localparam int MEM_DEPTH = 2 * PAT_DEPTH;
  localparam int MEM_AW    = ADDR_W + 1;

  logic [BLK_W-1:0]  blocks_q;
  loop_t             loops_a_q;
  loop_t             loops_b_q;
  logic [ADDR_W-1:0] rd_addr;
  logic              at_last;
  pat_sel_e          cur_sel;
  logic              cycle_end;

  ab_cfg_latch #(
    .MAX_BLOCKS (MAX_BLOCKS),
    .BLK_W      (BLK_W)
  ) u_cfg (
    .clk         (clk),
    .rst         (rst),
    .load        (cycle_end),
    .cfg_blocks  (cfg_blocks),
    .cfg_loops_a (cfg_loops_a),
    .cfg_loops_b (cfg_loops_b),
    .blocks_q    (blocks_q),
    .loops_a_q   (loops_a_q),
    .loops_b_q   (loops_b_q)
  );

  ab_addr_gen #(
    .BLOCK_BITS (BLOCK_BITS),
    .MAX_BLOCKS (MAX_BLOCKS),
    .BLK_W      (BLK_W),
    .ADDR_W     (ADDR_W)
  ) u_addr (
    .clk     (clk),
    .rst     (rst),
    .blocks  (blocks_q),
    .addr    (rd_addr),
    .at_last (at_last)
  );

  ab_loop_ctrl u_loop (
    .clk       (clk),
    .rst       (rst),
    .at_last   (at_last),
    .loops_a   (loops_a_q),
    .loops_b   (loops_b_q),
    .cur_sel   (cur_sel),
    .cycle_end (cycle_end)
  );

  // pattern select forms the top address bit: one RAM holds both patterns
  ab_pat_mem #(
    .DEPTH (MEM_DEPTH),
    .AW    (MEM_AW)
  ) u_mem (
    .clk   (clk),
    .rst   (rst),
    .we    (wr_en),
    .waddr ({wr_sel, wr_addr}),
    .wdata (wr_data),
    .raddr ({cur_sel, rd_addr}),
    .q     (dout)
  );

  // status registers aligned with the RAM read stage
  always_ff @(posedge clk) begin
    if (rst) begin
      pat_is_b   <= 1'b0;
      pass_start <= 1'b0;
    end else begin
      pat_is_b   <= (cur_sel == PAT_B);
      pass_start <= (rd_addr == '0);
    end
  end

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!dout && !pat_is_b && !pass_start));

  a_r8_sel_moves_at_start: assert property (@(posedge clk) disable iff (rst)
    !$stable(pat_is_b) |-> (pass_start || $past(rst)));

endmodule

// File: tb/ab_pattern_sequencer_test.sv
module ab_pattern_sequencer_test;

  localparam int BLOCK_BITS = 128;
  localparam int MAX_BLOCKS = 8;
  localparam int DEPTH      = BLOCK_BITS * MAX_BLOCKS;
  localparam int WATCHDOG   = 190000;

  typedef struct packed {
    int blocks;
    int la;
    int lb;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    '{1, 1, 1},
    '{1, 3, 2},
    '{2, 2, 1},
    '{0, 0, 0},
    '{15, 1, 1},
    '{1, 127, 1},
    '{1, 1, 127}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic       wr_sel = 1'b0;
  logic [9:0] wr_addr = '0;
  logic       wr_data = 1'b0;
  logic [3:0] cfg_blocks = 4'd1;
  logic [6:0] cfg_loops_a = 7'd1;
  logic [6:0] cfg_loops_b = 7'd1;
  logic       dout, pat_is_b, pass_start;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;
  bit  ma [DEPTH];
  bit  mb [DEPTH];

  always #4 clk = ~clk;

  ab_pattern_sequencer #(
    .BLOCK_BITS (BLOCK_BITS),
    .MAX_BLOCKS (MAX_BLOCKS)
  ) uut (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_sel      (wr_sel),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .cfg_blocks  (cfg_blocks),
    .cfg_loops_a (cfg_loops_a),
    .cfg_loops_b (cfg_loops_b),
    .dout        (dout),
    .pat_is_b    (pat_is_b),
    .pass_start  (pass_start)
  );

  function automatic bit gen_a(int i);
    int v = ((i * 13) ^ (i >> 3)) & 12'hFFF;
    return ^v[11:0];
  endfunction

  function automatic bit gen_b(int i);
    int v = ((i * 29 + 5) ^ (i >> 2)) & 12'hFFF;
    return ^v[11:0];
  endfunction

  function automatic int eff_blocks(int b);
    if (b == 0) return 1;
    if (b > MAX_BLOCKS) return MAX_BLOCKS;
    return b;
  endfunction

  function automatic int eff_loops(int c);
    return (c == 0) ? 1 : c;
  endfunction

  // expected {dout, pat_is_b, pass_start} for output index n after reset
  function automatic logic [2:0] model(int n, int blk, int la, int lb);
    int len = eff_blocks(blk) * BLOCK_BITS;
    int a   = eff_loops(la);
    int b   = eff_loops(lb);
    int per = (a + b) * len;
    int m   = n % per;
    int ps  = m / len;
    int bi  = m % len;
    bit isb = (ps >= a);
    bit d   = isb ? mb[bi] : ma[bi];
    return {d, isb, (bi == 0)};
  endfunction

  function automatic int period(int blk, int la, int lb);
    return (eff_loops(la) + eff_loops(lb)) * eff_blocks(blk) * BLOCK_BITS;
  endfunction

  function automatic string vec_tag(int idx);
    case (idx)
      3:       return "R4 R6";
      4:       return "R4";
      5, 6:    return "R6 R5";
      default: return "R5";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic write_bit(input bit sel, input int idx, input bit val);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_sel  = sel;
    wr_addr = 10'(idx);
    wr_data = val;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  // apply config, one reset edge, release; next negedge holds index 0
  task automatic restart(input int blk, input int la, input int lb);
    @(negedge clk);
    cfg_blocks  = 4'(blk);
    cfg_loops_a = 7'(la);
    cfg_loops_b = 7'(lb);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
  endtask

  // compare ncyc outputs against the model; returns per-signal mismatches
  task automatic compare_run(input int base, input int ncyc, input int blk,
                             input int la, input int lb,
                             inout int ed, inout int eb, inout int es);
    for (int n = 0; n < ncyc; n++) begin
      logic [2:0] e;
      @(negedge clk);
      e = model(base + n, blk, la, lb);
      if (dout !== e[2]) begin
        if (ed == 0) $display("  dout mismatch idx=%0d got=%0b want=%0b", base + n, dout, e[2]);
        ed++;
      end
      if (pat_is_b !== e[1]) begin
        if (eb == 0) $display("  sel mismatch idx=%0d got=%0b want=%0b", base + n, pat_is_b, e[1]);
        eb++;
      end
      if (pass_start !== e[0]) begin
        if (es == 0) $display("  start mismatch idx=%0d got=%0b want=%0b", base + n, pass_start, e[0]);
        es++;
      end
    end
  endtask

  initial begin : watchdog
    for (int c = 0; c < WATCHDOG; c++) begin
      @(posedge clk);
      if (done) disable watchdog;
    end
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", WATCHDOG, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    // R2: load both patterns while held in reset
    for (int i = 0; i < DEPTH; i++) begin
      ma[i] = gen_a(i);
      mb[i] = gen_b(i);
    end
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      wr_en = 1'b1; wr_sel = 1'b0; wr_addr = 10'(i); wr_data = ma[i];
      @(negedge clk);
      wr_sel = 1'b1; wr_data = mb[i];
    end
    @(negedge clk);
    wr_en = 1'b0;

    // R1: reset state and first bit after release
    @(negedge clk);
    check(dout === 1'b0, "R1", "dout in reset", int'(dout), 0);
    check(pat_is_b === 1'b0, "R1", "pat_is_b in reset", int'(pat_is_b), 0);
    check(pass_start === 1'b0, "R1", "pass_start in reset", int'(pass_start), 0);
    restart(1, 1, 1);
    @(negedge clk);
    check(pass_start === 1'b1 && pat_is_b === 1'b0 && dout === ma[0], "R1",
          "first bit {dout,sel,start}", int'({dout, pat_is_b, pass_start}),
          int'({ma[0], 1'b0, 1'b1}));

    // table of configurations, one loop
    for (int v = 0; v < NVEC; v++) begin
      int ed = 0, eb = 0, es = 0;
      int blk = VECS[v].blocks;
      int la  = VECS[v].la;
      int lb  = VECS[v].lb;
      int ncyc = period(blk, la, lb) + eff_blocks(blk) * BLOCK_BITS;
      restart(blk, la, lb);
      compare_run(0, ncyc, blk, la, lb, ed, eb, es);
      check(ed == 0, {vec_tag(v), " R3"}, $sformatf("vec%0d dout mismatches", v), ed, 0);
      check(eb == 0, {vec_tag(v), " R8"}, $sformatf("vec%0d pat_is_b mismatches", v), eb, 0);
      check(es == 0, "R7", $sformatf("vec%0d pass_start mismatches", v), es, 0);
    end

    // R9: config change mid-cycle applies only from the next cycle
    begin
      int ed = 0, eb = 0, es = 0;
      int p_old = period(1, 2, 1);
      restart(1, 2, 1);
      compare_run(0, 50, 1, 2, 1, ed, eb, es);
      cfg_blocks = 4'd2; cfg_loops_a = 7'd1; cfg_loops_b = 7'd1;
      compare_run(50, p_old - 50, 1, 2, 1, ed, eb, es);
      compare_run(0, 2 * period(2, 1, 1), 2, 1, 1, ed, eb, es);
      check(ed + eb + es == 0, "R9", "mid-cycle config change mismatches",
            ed + eb + es, 0);

      // R1: reset in the middle of a B pass restarts at A bit 0
      compare_run(0, 300, 2, 1, 1, ed, eb, es);
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      check({dout, pat_is_b, pass_start} === 3'b000, "R1", "mid-run reset outputs",
            int'({dout, pat_is_b, pass_start}), 0);
      rst = 1'b0;
      @(negedge clk);
      check(pass_start === 1'b1 && pat_is_b === 1'b0 && dout === ma[0], "R1",
            "restart bit {dout,sel,start}", int'({dout, pat_is_b, pass_start}),
            int'({ma[0], 1'b0, 1'b1}));
    end

    // R2: overwrite one bit of A only; B at the same index keeps its value
    begin
      int ed = 0, eb = 0, es = 0;
      bit a5, b5;
      ma[5] = ~ma[5];
      write_bit(1'b0, 5, ma[5]);
      restart(1, 1, 1);
      for (int n = 0; n < 256; n++) begin
        @(negedge clk);
        if (n == 5) a5 = dout;
        if (n == 133) b5 = dout;
      end
      check(a5 === ma[5], "R2", "rewritten A bit 5", int'(a5), int'(ma[5]));
      check(b5 === mb[5], "R2", "untouched B bit 5", int'(b5), int'(mb[5]));
      restart(1, 1, 1);
      compare_run(0, 256, 1, 1, 1, ed, eb, es);
      check(ed == 0, "R2", "stream after rewrite mismatches", ed, 0);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule